// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits on the bus side of a small 8-bit CPU. The CPU core passes it one machine-cycle request at a time. A request carries a cycle type, a 16-bit address and, for writes, a byte of data. The sequencer runs the external bus through the clocks of that cycle.

In the first clock it pulses the address strobe and drives the low address byte on a shared address/data bus. The high address byte has pins of its own. The sequencer then turns the shared bus over to data and asserts exactly one of the read, write or interrupt-acknowledge strobes. For every cycle it presents a three-bit status code. A slow device can stretch the cycle by holding `ready_i` low. Read data is captured when the strobe ends. Between cycles another bus master may request the bus. The sequencer grants it only at a cycle boundary: it first raises an acknowledge, then tristates its pins.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, `ale_o` is 0 and all three strobes are high. `hlda_o` is 0, `strobe_oe_o` and `addr_hi_oe_o` are 1, and `done_o` is 0.
- R2: A request is accepted when the sequencer is idle or in the last clock of a cycle, `hold_i` is low and the type is supported. On acceptance, `req_ack_o` is high in that same cycle. In the next clock `ale_o` is 1, and `ad_o` carries address bits 7:0 with `ad_oe_o` high. `addr_hi_o` carries address bits 15:8.
- R3: The type codes are 0 memory read, 1 I/O read, 2 memory write, 3 I/O write, 4 opcode fetch and 5 interrupt acknowledge. From the address clock to the last clock, {s0_o,s1_o,io_m_o} is 010, 011, 100, 101, 110 and 111 respectively, and `io_m_oe_o` is 1.
- R4: Memory read, I/O read and opcode fetch drive `rd_n_o` low. The two write types drive `wr_n_o` low. Interrupt acknowledge drives `inta_n_o` low. The strobe is low from the second clock through the last clock, and it is never low while `ale_o` is 1. At most one strobe is low at any time.
- R5: Each rising edge that ends the second clock or a wait clock with `ready_i` low adds one wait clock. During a wait clock the strobe stays low and `done_o` stays 0.
- R6: `done_o` is 1 only in the last clock of a cycle. For non-write cycles, `ad_i` is captured into `rdata_o` on the edge that ends that clock.
- R7: In write cycles, `ad_o` carries the write byte with `ad_oe_o` high from the second clock onward. It stays driven after the cycle until the next address clock or until the bus is released.
- R8: In non-write cycles, `ad_oe_o` is 0 from the second clock through the last clock.
- R9: A `hold_i` raised during a cycle does not shorten it. At the next boundary, `hlda_o` goes high for one clock while the pins are still driven. After that, `ad_oe_o`, `addr_hi_oe_o`, `strobe_oe_o` and `io_m_oe_o` are all 0.
- R10: While `hlda_o` is high, no request is accepted. One clock after `hold_i` is seen low, `hlda_o` is 0 and the pins are driven again, and a pending request may then be accepted.
- R11: Requests with type code 6 or 7 are ignored: `req_ack_o` stays 0 and no address clock follows.
- R12: A request presented in the last clock of a cycle is accepted there, and its address clock follows with no idle clock in between.
- R13: When idle, {s0_o,s1_o} is 00 and `io_m_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cycle request present |
| req_type_i | input | 3 | Cycle type code |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write byte |
| req_ack_o | output | 1 | Request accepted this clock |
| done_o | output | 1 | Last clock of a cycle |
| rdata_o | output | 8 | Captured read byte |
| ready_i | input | 1 | Device ready; low inserts waits |
| hold_i | input | 1 | External master requests the bus |
| hlda_o | output | 1 | Hold acknowledge |
| ale_o | output | 1 | Address latch strobe |
| s0_o | output | 1 | Status bit 0 |
| s1_o | output | 1 | Status bit 1 |
| io_m_o | output | 1 | I/O (1) or memory (0) |
| io_m_oe_o | output | 1 | Enable for io_m_o |
| addr_hi_o | output | 8 | Address bits 15:8 |
| addr_hi_oe_o | output | 1 | Enable for addr_hi_o |
| ad_o | output | 8 | Shared bus, outgoing value |
| ad_oe_o | output | 1 | Enable for ad_o |
| ad_i | input | 8 | Shared bus, incoming value |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| strobe_oe_o | output | 1 | Enable for the three strobes |

## Verification
The assertions check several rules on every clock:
- no two strobes are low together, and none is low during the address strobe;
- a strobe, once low, stays low until the done clock;
- the address clock always drives the bus;
- a request is never accepted while hold is acknowledged;
- the second clock of an acknowledged hold has all pins released.

Other behaviour can only be shown by the bench scenarios:
- the exact status code for each type;
- the number of wait clocks for a given `ready_i` pattern;
- the value captured from `ad_i`;
- write data lingering after the strobe;
- a hold raised mid-cycle being deferred to the boundary;
- back-to-back acceptance.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    CYC_MEM_RD = 3'd0,
    CYC_IO_RD  = 3'd1,
    CYC_MEM_WR = 3'd2,
    CYC_IO_WR  = 3'd3,
    CYC_FETCH  = 3'd4,
    CYC_INTA   = 3'd5
  } cyc_type_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HACK, ST_HOLD
  } seq_state_e;

  typedef struct packed {
    logic s0;
    logic s1;
    logic io_m;
  } bus_status_t;

  function automatic logic type_ok(input logic [2:0] t);
    return t <= 3'd5;
  endfunction
endpackage

// File: rtl/mbs_seq_fsm.sv
module mbs_seq_fsm
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              req_ack_o,
  output seq_state_e        state_o,
  output cyc_type_e         cur_type_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [DATA_W-1:0] cur_wdata_o,
  output logic              done_o
);
  seq_state_e state_q, state_d;
  logic boundary;

  assign boundary  = (state_q == ST_IDLE) || (state_q == ST_T3);
  assign req_ack_o = boundary && req_valid_i && type_ok(req_type_i) && !hold_i;
  assign done_o    = (state_q == ST_T3);
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_T3: begin
        if (hold_i)         state_d = ST_HACK;
        else if (req_ack_o) state_d = ST_T1;
        else                state_d = ST_IDLE;
      end
      ST_T1:        state_d = ST_T2;
      ST_T2, ST_TW: state_d = ready_i ? ST_T3 : ST_TW;
      ST_HACK:      state_d = ST_HOLD;
      ST_HOLD:      state_d = hold_i ? ST_HOLD : ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_type_o  <= CYC_MEM_RD;
      cur_addr_o  <= '0;
      cur_wdata_o <= '0;
    end else begin
      state_q <= state_d;
      if (req_ack_o) begin
        cur_type_o  <= cyc_type_e'(req_type_i);
        cur_addr_o  <= req_addr_i;
        cur_wdata_o <= req_wdata_i;
      end
    end
  end
endmodule

// File: rtl/mbs_status_enc.sv
module mbs_status_enc
  import mbs_pkg::*;
(
  input  cyc_type_e   type_i,
  input  seq_state_e  state_i,
  output bus_status_t status_o,
  output logic        io_m_oe_o,
  output logic        sel_rd_o,
  output logic        sel_wr_o,
  output logic        sel_inta_o
);
  logic in_cycle;
  bus_status_t code;

  assign in_cycle = (state_i == ST_T1) || (state_i == ST_T2) ||
                    (state_i == ST_TW) || (state_i == ST_T3);

  always_comb begin
    code       = '0;
    sel_rd_o   = 1'b0;
    sel_wr_o   = 1'b0;
    sel_inta_o = 1'b0;
    unique case (type_i)
      CYC_MEM_RD: begin code = 3'b010; sel_rd_o   = 1'b1; end
      CYC_IO_RD:  begin code = 3'b011; sel_rd_o   = 1'b1; end
      CYC_MEM_WR: begin code = 3'b100; sel_wr_o   = 1'b1; end
      CYC_IO_WR:  begin code = 3'b101; sel_wr_o   = 1'b1; end
      CYC_FETCH:  begin code = 3'b110; sel_rd_o   = 1'b1; end
      CYC_INTA:   begin code = 3'b111; sel_inta_o = 1'b1; end
      default:    code = 3'b000;
    endcase
  end

  // outside a cycle: halt code, io/m released
  assign status_o  = in_cycle ? code : '0;
  assign io_m_oe_o = in_cycle;
endmodule

// File: rtl/mbs_pin_drv.sv
module mbs_pin_drv
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel_rd_i,
  input  logic              sel_wr_i,
  input  logic              sel_inta_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              addr_hi_oe_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              strobe_oe_o,
  output logic              hlda_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic strobe_on, keep_wr_q, released;

  assign strobe_on = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
  assign released  = (state_i == ST_HOLD);

  assign ale_o        = (state_i == ST_T1);
  assign hlda_o       = (state_i == ST_HACK) || released;
  assign strobe_oe_o  = !released;
  assign addr_hi_oe_o = !released;
  assign addr_hi_o    = addr_i[ADDR_W-1:DATA_W];

  assign rd_n_o   = !(strobe_on && sel_rd_i);
  assign wr_n_o   = !(strobe_on && sel_wr_i);
  assign inta_n_o = !(strobe_on && sel_inta_i);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    if (ale_o) begin
      ad_o    = addr_i[DATA_W-1:0];
      ad_oe_o = 1'b1;
    end else if ((strobe_on && sel_wr_i) || (keep_wr_q && !released)) begin
      ad_o    = wdata_i;
      ad_oe_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_wr_q <= 1'b0;
      rdata_o   <= '0;
    end else begin
      if (state_i == ST_T3 && sel_wr_i)                 keep_wr_q <= 1'b1;
      else if (state_i == ST_T1 || state_i == ST_HOLD)  keep_wr_q <= 1'b0;
      if (state_i == ST_T3 && !sel_wr_i)                rdata_o   <= ad_i;
    end
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o,
  output logic              ale_o,
  output logic              s0_o,
  output logic              s1_o,
  output logic              io_m_o,
  output logic              io_m_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              addr_hi_oe_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              inta_n_o,
  output logic              strobe_oe_o
);
  seq_state_e        state;
  cyc_type_e         cur_type;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  bus_status_t       status;
  logic              sel_rd, sel_wr, sel_inta;

  mbs_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .req_valid_i, .req_type_i, .req_addr_i, .req_wdata_i,
    .ready_i, .hold_i, .req_ack_o,
    .state_o(state), .cur_type_o(cur_type), .cur_addr_o(cur_addr),
    .cur_wdata_o(cur_wdata), .done_o
  );

  mbs_status_enc u_enc (
    .type_i(cur_type), .state_i(state), .status_o(status), .io_m_oe_o,
    .sel_rd_o(sel_rd), .sel_wr_o(sel_wr), .sel_inta_o(sel_inta)
  );

  assign s0_o   = status.s0;
  assign s1_o   = status.s1;
  assign io_m_o = status.io_m;

  mbs_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk_i, .rst_ni, .state_i(state), .addr_i(cur_addr), .wdata_i(cur_wdata),
    .sel_rd_i(sel_rd), .sel_wr_i(sel_wr), .sel_inta_i(sel_inta), .ad_i,
    .ale_o, .ad_o, .ad_oe_o, .addr_hi_o, .addr_hi_oe_o,
    .rd_n_o, .wr_n_o, .inta_n_o, .strobe_oe_o, .hlda_o, .rdata_o
  );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ack_o,
  input logic done_o,
  input logic hlda_o,
  input logic ale_o,
  input logic io_m_oe_o,
  input logic addr_hi_oe_o,
  input logic ad_oe_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic inta_n_o,
  input logic strobe_oe_o
);
  logic strobe_any;
  assign strobe_any = !(rd_n_o && wr_n_o && inta_n_o);

  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!rd_n_o, !wr_n_o, !inta_n_o}) <= 1);

  a_r4_quiet_in_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !strobe_any);

  a_r2_ale_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && io_m_oe_o && addr_hi_oe_o));

  a_r5_strobe_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_any && !done_o) |=> strobe_any);

  a_r6_done_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (strobe_any && !ale_o));

  a_r10_no_ack_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !req_ack_o);

  a_r9_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && $past(hlda_o)) |->
      (!ad_oe_o && !addr_hi_oe_o && !strobe_oe_o && !io_m_oe_o));
endmodule

bind mux_bus_seq mbs_checker u_mbs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ack_o(req_ack_o), .done_o(done_o),
  .hlda_o(hlda_o), .ale_o(ale_o), .io_m_oe_o(io_m_oe_o),
  .addr_hi_oe_o(addr_hi_oe_o), .ad_oe_o(ad_oe_o), .rd_n_o(rd_n_o),
  .wr_n_o(wr_n_o), .inta_n_o(inta_n_o), .strobe_oe_o(strobe_oe_o)
);

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ready = 1, hold = 0;
  logic [2:0] req_type = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, ad_in = 0;
  logic req_ack, done, hlda, ale, s0, s1, io_m, io_m_oe, addr_hi_oe, ad_oe;
  logic rd_n, wr_n, inta_n, strobe_oe;
  logic [7:0] rdata, addr_hi, ad_out;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ack_o(req_ack),
    .done_o(done), .rdata_o(rdata), .ready_i(ready), .hold_i(hold),
    .hlda_o(hlda), .ale_o(ale), .s0_o(s0), .s1_o(s1), .io_m_o(io_m),
    .io_m_oe_o(io_m_oe), .addr_hi_o(addr_hi), .addr_hi_oe_o(addr_hi_oe),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .rd_n_o(rd_n),
    .wr_n_o(wr_n), .inta_n_o(inta_n), .strobe_oe_o(strobe_oe)
  );

  typedef struct packed {
    logic [2:0]  typ;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [1:0]  waits;
    logic [2:0]  stat;   // {s0,s1,io_m}
    logic [1:0]  strb;   // 0 rd, 1 wr, 2 inta
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'h1234, 8'h00, 8'hA5, 2'd0, 3'b010, 2'd0},
    '{3'd1, 16'h00F0, 8'h00, 8'h3C, 2'd1, 3'b011, 2'd0},
    '{3'd2, 16'h8001, 8'h5A, 8'h00, 2'd0, 3'b100, 2'd1},
    '{3'd3, 16'h0044, 8'hC3, 8'h00, 2'd2, 3'b101, 2'd1},
    '{3'd4, 16'h2000, 8'h00, 8'h90, 2'd0, 3'b110, 2'd0},
    '{3'd5, 16'h0000, 8'h00, 8'hCD, 2'd1, 3'b111, 2'd2},
    '{3'd0, 16'hFFFF, 8'h00, 8'h00, 2'd3, 3'b010, 2'd0},
    '{3'd2, 16'h0000, 8'hFF, 8'h00, 2'd1, 3'b100, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #3;
  endtask

  function automatic logic [2:0] strb_pat(input logic [1:0] k);
    case (k)
      2'd0: return 3'b011;
      2'd1: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    logic is_wr;
    is_wr = (v.strb == 2'd1);
    req_valid = 1; req_type = v.typ; req_addr = v.addr; req_wdata = v.wd;
    #1 chk("R2 accept", req_ack, 1);
    tick(); req_valid = 0;
    chk("R2 ale", ale, 1);
    chk("R2 low addr", ad_out, v.addr[7:0]);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 high addr", addr_hi, v.addr[15:8]);
    chk("R3 status T1", {s0, s1, io_m}, v.stat);
    chk("R3 io_m_oe", io_m_oe, 1);
    chk("R4 no strobe in T1", {rd_n, wr_n, inta_n}, 3'b111);
    tick(); ready = (v.waits == 0); ad_in = v.rd;
    chk("R4 strobe T2", {rd_n, wr_n, inta_n}, strb_pat(v.strb));
    chk("R3 status T2", {s0, s1, io_m}, v.stat);
    chk("R2 ale low T2", ale, 0);
    if (is_wr) begin
      chk("R7 wdata T2", ad_out, v.wd);
      chk("R7 oe T2", ad_oe, 1);
    end else chk("R8 bus released T2", ad_oe, 0);
    for (int w = 0; w < v.waits; w++) begin
      tick(); ready = (w == v.waits - 1);
      chk("R5 strobe in wait", {rd_n, wr_n, inta_n}, strb_pat(v.strb));
      chk("R5 not done in wait", done, 0);
    end
    tick(); ready = 1;
    chk("R6 done in T3", done, 1);
    chk("R4 strobe T3", {rd_n, wr_n, inta_n}, strb_pat(v.strb));
    if (!is_wr) chk("R8 bus released T3", ad_oe, 0);
    tick();
    chk("R13 idle status", {s0, s1}, 2'b00);
    chk("R13 idle io_m_oe", io_m_oe, 0);
    chk("R4 idle strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R6 done drops", done, 0);
    if (is_wr) begin
      chk("R7 wdata lingers", ad_out, v.wd);
      chk("R7 oe lingers", ad_oe, 1);
    end else chk("R6 rdata", rdata, v.rd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R1 hlda", hlda, 0);
    chk("R1 strobe_oe", strobe_oe, 1);
    chk("R1 addr_hi_oe", addr_hi_oe, 1);
    chk("R1 done", done, 0);
    chk("R13 reset halt", {s0, s1, io_m_oe}, 3'b000);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R11 unsupported types ignored
    for (int t = 6; t < 8; t++) begin
      req_valid = 1; req_type = 3'(t);
      #1 chk("R11 no accept", req_ack, 0);
      tick();
      chk("R11 no ale", ale, 0);
      chk("R11 stays idle", io_m_oe, 0);
    end
    req_valid = 0;

    // R9/R10 hold raised mid write, deferred to boundary
    req_valid = 1; req_type = 3'd2; req_addr = 16'h0301; req_wdata = 8'h77;
    tick(); req_valid = 0;          // T1
    tick(); ready = 0; hold = 1;    // T2
    tick(); ready = 1;              // TW
    chk("R9 no hlda mid cycle", hlda, 0);
    chk("R9 strobe kept", wr_n, 0);
    tick();                         // T3
    chk("R9 cycle completes", done, 1);
    chk("R9 hlda not yet", hlda, 0);
    tick();                         // hold acknowledge
    chk("R9 hlda raised", hlda, 1);
    chk("R9 still driven", strobe_oe, 1);
    chk("R7 data until release", ad_out, 8'h77);
    req_valid = 1; req_type = 3'd0; req_addr = 16'h0400;
    #1 chk("R10 no accept in hold", req_ack, 0);
    tick();                         // released
    chk("R9 hlda held", hlda, 1);
    chk("R9 ad released", ad_oe, 0);
    chk("R9 hi released", addr_hi_oe, 0);
    chk("R9 strobes released", strobe_oe, 0);
    chk("R9 io_m released", io_m_oe, 0);
    hold = 0;
    #1 chk("R10 no accept before retake", req_ack, 0);
    tick();
    chk("R10 hlda drops", hlda, 0);
    chk("R10 retake strobes", strobe_oe, 1);
    chk("R10 retake hi", addr_hi_oe, 1);
    #1 chk("R10 accept after retake", req_ack, 1);
    tick(); req_valid = 0;
    chk("R10 ale after retake", ale, 1);
    chk("R10 addr after retake", ad_out, 8'h00);
    tick(); tick(); tick();

    // R9 hold from idle
    hold = 1;
    tick();
    chk("R9 idle hlda", hlda, 1);
    chk("R9 idle still driven", strobe_oe, 1);
    tick();
    chk("R9 idle released", strobe_oe, 0);
    hold = 0;
    tick();
    chk("R10 idle retake", hlda, 0);

    // R12 back-to-back
    req_valid = 1; req_type = 3'd0; req_addr = 16'h1111;
    tick(); req_valid = 0;
    tick(); ready = 1; ad_in = 8'h42;
    tick();
    chk("R12 in T3", done, 1);
    req_valid = 1; req_type = 3'd4; req_addr = 16'h2222;
    #1 chk("R12 accept in T3", req_ack, 1);
    tick(); req_valid = 0;
    chk("R12 ale next", ale, 1);
    chk("R12 addr next", ad_out, 8'h22);
    chk("R12 status next", {s0, s1, io_m}, 3'b110);
    chk("R6 rdata first", rdata, 8'h42);
    ad_in = 8'h17;
    tick(); tick(); tick();
    chk("R6 rdata second", rdata, 8'h17);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule